// File: doc/BRIEF.md
# Serial EEPROM Emulation Slave on a Two-Wire Bus

This block is a two-wire serial bus slave that fronts an on-chip 2K x 8 byte array, so that a master on the bus sees it as a small serial EEPROM. It oversamples the bus clock and data lines with the system clock and recognises START and STOP conditions. It decodes a device select byte whose middle three bits give the top three address bits. It accepts single-byte and page writes and serves sequential reads. It pulls the data line low through an open-drain enable output.

Write data collects in a 16-byte page buffer. The buffer is committed to the array only when the master sends STOP. A timed programming cycle follows, and the slave does not answer the bus while it runs. A write-protect input lets writes complete on the bus without changing the array. There is no streaming interface. The bus pins and the write-protect pin are plain control signals, and the bus itself cannot apply back-pressure because clock stretching is not supported.

Top module: `ee_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one aborts any transfer in progress, and `sda_drive_o` is low in the cycle after a STOP is detected.
- R2: A select byte is acknowledged only when its bits 7:4 are 1010. Any other value gets no acknowledge (SDA stays released). The slave then ignores the bus, including later bytes, until the next START.
- R3: The slave acknowledges a matching select byte, the word address byte and every write data byte by driving SDA low for the whole ninth SCL period. It changes its SDA drive only after an SCL falling edge, a START or a STOP.
- R4: Select bits 3:1 supply array address bits 10:8, and the word address byte supplies bits 7:0. Select bit 0 is the direction: 0 means write and 1 means read.
- R5: In a byte write (select with direction 0, address, one data byte, STOP), the byte reaches the addressed location, and a read issued after the programming cycle returns it. A STOP that follows write data starts the programming cycle in the next cycle.
- R6: A page write accepts any number of data bytes and acknowledges each one. Only address bits 3:0 advance, wrapping inside the 16-byte page. A 17th or later byte overwrites the byte buffered earlier at the same offset. All buffered bytes are committed in a single programming cycle.
- R7: The programming cycle lasts PROG_CLKS system clocks. While it runs, the slave drives SDA for nothing and acknowledges no select byte.
- R8: A STOP with no write data byte received since the last START starts no programming cycle. A repeated START discards buffered write data.
- R9: When `wp_i` is high at the STOP, every byte is still acknowledged but the array is left unchanged.
- R10: Read data is shifted out MSB first, and SDA is released in the ninth period. If the master acknowledges, the next byte comes from the incremented 11-bit pointer, which wraps from 0x7FF to 0x000. On no acknowledge the slave stays released until the next START or STOP.
- R11: A read select without a preceding address reads from the internal pointer with bits 10:8 taken from the select byte. A write select plus word address, followed by a repeated START and a read select, performs a random read from that address.
- R12: After reset `sda_drive_o` is low and the slave is not in a programming cycle, so the first select byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write protect; when high at STOP the array is not changed |
| sda_drive_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The hardest state to reach is a bus request that arrives while the programming cycle is still counting. The bench reaches it by issuing a START and a select byte straight after the STOP that ends a write, well inside the PROG_CLKS window, and then expects no acknowledge. A second case needs care: the page wrap requires more than 16 data bytes starting near the end of a page. This is reached with an 18-byte write from offset 0xE, and the overwritten offsets are then read back in one sequential read. A third case is a repeated START placed after a write data byte, followed by a check that the earlier array contents remain.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
package ee_pkg;
  localparam logic [3:0] EE_DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_HOLD
  } ee_state_t;
endpackage

// File: rtl/ee_bus_sync.sv
`timescale 1ns/1ps
module ee_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // one extra stage holds the previous synchronized value
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now   = scl_pipe[DEPTH-2];
  assign scl_old   = scl_pipe[DEPTH-1];
  assign sda_s     = sda_pipe[DEPTH-2];
  assign sda_old   = sda_pipe[DEPTH-1];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/ee_array.sv
`timescale 1ns/1ps
module ee_array #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int PROG_CLKS = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_wdata,
  input  logic                     buf_clr,
  input  logic                     commit_go,
  input  logic [ADDR_W-1:PAGE_W]   page_base,
  input  logic                     wp,
  output logic                     busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(PROG_CLKS + 1);

  logic [7:0]               mem  [DEPTH];
  logic [7:0]               pbuf [PAGE];
  logic [PAGE-1:0]          pval;
  logic [CW-1:0]            busy_cnt;
  logic [ADDR_W-1:PAGE_W]   base_q;
  logic                     wp_q;
  logic                     wr_en;
  logic [PAGE_W-1:0]        slot;

  assign rd_data = mem[rd_addr];
  assign slot    = busy_cnt[PAGE_W-1:0];
  // one buffered byte drains per clock during the first PAGE cycles
  assign wr_en   = busy && (busy_cnt < CW'(PAGE)) && pval[slot] && !wp_q;

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_wdata;
    if (wr_en)  mem[{base_q, slot}] <= pbuf[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_cnt <= '0;
      base_q   <= '0;
      wp_q     <= 1'b0;
      pval     <= '0;
    end else if (commit_go) begin
      busy     <= 1'b1;
      busy_cnt <= '0;
      base_q   <= page_base;
      wp_q     <= wp;
    end else if (busy) begin
      if (busy_cnt == CW'(PROG_CLKS - 1)) begin
        busy <= 1'b0;
        pval <= '0;
      end else begin
        busy_cnt <= busy_cnt + 1'b1;
      end
    end else if (buf_clr) begin
      pval <= '0;
    end else if (buf_we) begin
      pval[buf_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/ee_proto.sv
`timescale 1ns/1ps
module ee_proto
  import ee_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sda_s,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic                   busy,
  input  logic [7:0]             rd_data,
  output logic [ADDR_W-1:0]      ptr,
  output logic                   buf_we,
  output logic [PAGE_W-1:0]      buf_idx,
  output logic [7:0]             buf_wdata,
  output logic                   buf_clr,
  output logic                   commit_go,
  output logic                   sda_drive
);
  localparam int HI_W = ADDR_W - 8;

  ee_state_t   state, nxt;
  logic [2:0]  bit_cnt;
  logic        last_bit;
  logic [7:0]  shreg, txreg;
  logic        pend;
  logic        mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  nxt <= ST_IDLE;
      bit_cnt <= '0;     last_bit <= 1'b0;
      shreg <= '0;       txreg <= '0;
      ptr <= '0;         pend <= 1'b0;  mack <= 1'b0;
      buf_we <= 1'b0;    buf_idx <= '0; buf_wdata <= '0;
      buf_clr <= 1'b0;   commit_go <= 1'b0;
      sda_drive <= 1'b0;
    end else begin
      buf_we    <= 1'b0;
      buf_clr   <= 1'b0;
      commit_go <= 1'b0;
      if (!busy && start_det) begin
        state <= ST_DEV;  bit_cnt <= '0;  last_bit <= 1'b0;
        sda_drive <= 1'b0; pend <= 1'b0;  buf_clr <= 1'b1;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_drive <= 1'b0;
        commit_go <= pend; pend <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) last_bit <= 1'b1;
            end else if (scl_fall && last_bit) begin
              last_bit <= 1'b0;
              if (state == ST_DEV) begin
                if (shreg[7:4] == EE_DEV_CODE) begin
                  ptr[ADDR_W-1:8] <= shreg[HI_W:1];
                  nxt       <= shreg[0] ? ST_RD : ST_WADDR;
                  sda_drive <= 1'b1;
                  state     <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_WADDR) begin
                ptr[7:0]  <= shreg;
                nxt       <= ST_WDATA;
                sda_drive <= 1'b1;
                state     <= ST_ACK;
              end else begin
                buf_we       <= 1'b1;
                buf_idx      <= ptr[PAGE_W-1:0];
                buf_wdata    <= shreg;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                pend         <= 1'b1;
                nxt          <= ST_WDATA;
                sda_drive    <= 1'b1;
                state        <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (nxt == ST_RD) begin
                txreg     <= rd_data;
                ptr       <= ptr + 1'b1;
                sda_drive <= ~rd_data[7];
                bit_cnt   <= '0;
              end else begin
                sda_drive <= 1'b0;
              end
              state <= nxt;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_drive <= 1'b0;
                state     <= ST_RACK;
              end else begin
                sda_drive <= ~txreg[6];
                txreg     <= {txreg[6:0], 1'b0};
                bit_cnt   <= bit_cnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                txreg     <= rd_data;
                ptr       <= ptr + 1'b1;
                sda_drive <= ~rd_data[7];
                bit_cnt   <= '0;
                state     <= ST_RD;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ee_i2c_slave.sv
`timescale 1ns/1ps
module ee_i2c_slave #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int PROG_CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_drive_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              busy, buf_we, buf_clr, commit_go;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rd_data, buf_wdata;
  logic [PAGE_W-1:0] buf_idx;

  ee_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .busy(busy), .rd_data(rd_data), .ptr(ptr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_clr(buf_clr),
    .commit_go(commit_go), .sda_drive(sda_drive_o)
  );

  ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CLKS(PROG_CLKS)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_clr(buf_clr), .commit_go(commit_go),
    .page_base(ptr[ADDR_W-1:PAGE_W]), .wp(wp_i), .busy(busy)
  );
endmodule

// File: rtl/ee_i2c_slave_chk.sv
`timescale 1ns/1ps
module ee_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic start_det,
  input logic stop_det,
  input logic scl_fall,
  input logic commit_go,
  input logic sda_drive
);
  // R1: STOP releases the data line one cycle later
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive);

  // R3: drive changes only after an SCL fall, START or STOP
  a_r3_drive_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R5: a commit request opens the programming cycle
  a_r5_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  // R7: silent while programming
  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_drive);
endmodule

bind ee_i2c_slave ee_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_det(start_det),
  .stop_det(stop_det), .scl_fall(scl_fall), .commit_go(commit_go),
  .sda_drive(sda_drive_o)
);

// File: tb/ee_i2c_slave_bench.sv
`timescale 1ns/1ps
module ee_i2c_slave_bench;
  localparam int PROG = 1000;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_drive;
  logic sda_line;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic nk;
  logic [7:0] rb [16];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive;

  ee_i2c_slave #(.ADDR_W(11), .PAGE_W(4), .PROG_CLKS(PROG)) u_ee_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wp_i(wp), .sda_drive_o(sda_drive)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    nack = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rx_byte(output logic [7:0] b, input logic ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic wait_prog();
    tick(PROG + 100);
  endtask

  // byte write; all three acknowledges checked
  task automatic byte_write(input string req, input logic [10:0] a, input logic [7:0] d);
    bus_start();
    tx_byte(sel(a, 1'b0), nk); chk({req, " R3 select ack"}, nk, 0);
    tx_byte(a[7:0], nk);       chk({req, " R3 addr ack"}, nk, 0);
    tx_byte(d, nk);            chk({req, " R3 data ack"}, nk, 0);
    bus_stop();
    wait_prog();
  endtask

  // random read of n bytes into rb
  task automatic rd_random(input logic [10:0] a, input int n);
    bus_start();
    tx_byte(sel(a, 1'b0), nk); chk("R11 rd select(w) ack", nk, 0);
    tx_byte(a[7:0], nk);       chk("R11 rd addr ack", nk, 0);
    bus_start();
    tx_byte(sel(a, 1'b1), nk); chk("R11 rd select(r) ack", nk, 0);
    for (int i = 0; i < n; i++) rx_byte(rb[i], i < n - 1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R12 reset drive", sda_drive, 0);
    bus_start();
    tx_byte(sel(11'h000, 1'b0), nk); chk("R12 not busy after reset", nk, 0);
    bus_stop();
  endtask

  task automatic t_bad_select();
    bus_start();
    tx_byte(8'h92, nk);  chk("R2 foreign select nack", nk, 1);
    tx_byte(8'hA0, nk);  chk("R2 ignored until START", nk, 1);
    bus_stop();
    chk("R1 released after stop", sda_drive, 0);
  endtask

  task automatic t_byte_and_busy();
    bus_start();
    tx_byte(sel(11'h5A7, 1'b0), nk); chk("R3 select ack", nk, 0);
    tx_byte(8'hA7, nk);              chk("R3 addr ack", nk, 0);
    tx_byte(8'h3D, nk);              chk("R3 data ack", nk, 0);
    bus_stop();
    bus_start();
    tx_byte(sel(11'h000, 1'b0), nk); chk("R7 no ack while programming", nk, 1);
    bus_stop();
    wait_prog();
    rd_random(11'h5A7, 1);
    chk("R5 R4 byte write readback", rb[0], 8'h3D);
  endtask

  task automatic t_page_wrap();
    bus_start();
    tx_byte(sel(11'h53E, 1'b0), nk); chk("R6 select ack", nk, 0);
    tx_byte(8'h3E, nk);              chk("R6 addr ack", nk, 0);
    for (int k = 0; k < 18; k++) begin
      tx_byte(8'h40 + 8'(k), nk);    chk("R6 data ack", nk, 0);
    end
    bus_stop();
    wait_prog();
    rd_random(11'h530, 16);
    for (int o = 0; o < 16; o++) begin
      int kk;
      kk = (o - 14) & 15;
      if (kk < 2) kk += 16;
      chk("R6 page wrap content", rb[o], 8'h40 + 8'(kk));
    end
  endtask

  task automatic t_wp();
    byte_write("R9 setup", 11'h100, 8'h22);
    wp = 1'b1;
    byte_write("R9 protected", 11'h100, 8'hEE);
    wp = 1'b0;
    rd_random(11'h100, 1);
    chk("R9 array unchanged", rb[0], 8'h22);
  endtask

  task automatic t_seq_wrap_and_current();
    byte_write("R10 setup", 11'h7FF, 8'hA5);
    bus_start();
    tx_byte(sel(11'h000, 1'b0), nk); chk("R6 two-byte select ack", nk, 0);
    tx_byte(8'h00, nk);              chk("R6 two-byte addr ack", nk, 0);
    tx_byte(8'h3C, nk);              chk("R6 byte0 ack", nk, 0);
    tx_byte(8'hC3, nk);              chk("R6 byte1 ack", nk, 0);
    bus_stop();
    wait_prog();
    rd_random(11'h7FF, 2);
    chk("R10 read at 0x7FF", rb[0], 8'hA5);
    chk("R10 pointer wraps to 0x000", rb[1], 8'h3C);
    chk("R10 released after nack", sda_drive, 0);
    bus_start();
    tx_byte(sel(11'h000, 1'b1), nk); chk("R11 current read select ack", nk, 0);
    rx_byte(rb[0], 1'b0);
    bus_stop();
    chk("R11 current address read", rb[0], 8'hC3);
  endtask

  task automatic t_no_commit();
    bus_start();
    tx_byte(sel(11'h050, 1'b0), nk); chk("R8 select ack", nk, 0);
    tx_byte(8'h50, nk);              chk("R8 addr ack", nk, 0);
    bus_stop();
    bus_start();
    tx_byte(sel(11'h000, 1'b0), nk); chk("R8 no programming without data", nk, 0);
    bus_stop();
    byte_write("R8 setup", 11'h060, 8'h11);
    bus_start();
    tx_byte(sel(11'h060, 1'b0), nk); chk("R8 select ack", nk, 0);
    tx_byte(8'h60, nk);              chk("R8 addr ack", nk, 0);
    tx_byte(8'h77, nk);              chk("R8 data ack", nk, 0);
    rd_random(11'h060, 1);
    chk("R8 repeated START discards data", rb[0], 8'h11);
    bus_start();
    tx_byte(sel(11'h000, 1'b0), nk); chk("R8 no programming after abort", nk, 0);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_bad_select();
    t_byte_and_busy();
    t_page_wrap();
    t_wp();
    t_seq_wrap_and_current();
    t_no_commit();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule